// File: doc/BRIEF.md
# Same-Address Contention Arbiter for a Two-Port Memory

This block sits beside a memory with two independent access ports, named left and right. On every clock it checks whether both ports are selected and present the same address. When they do, it lets one port carry on and raises an active-low busy flag toward the other port. It also produces one internal write enable per port, which goes to the storage array. A port's write enable is suppressed while that port has lost arbitration, so a late write from the losing side does not reach the array. Whether an access is a read or a write plays no part in the arbitration.

A mode input changes the block's role. In master mode the block arbitrates and drives the busy flags. In slave mode it does not arbitrate. Its busy outputs stay high, and each port's busy input becomes a write-inhibit line. Several arrays can then share one master's decision.

The core is a three-state machine. `ARB_IDLE` means no port is busy. `ARB_LEFT_WINS` means the right port is busy. `ARB_RIGHT_WINS` means the left port is busy. The transitions are as follows:
- IDLE→LEFT_WINS on a fresh contention, or when the left port already held the address.
- IDLE→RIGHT_WINS when only the right port held the address in the previous cycle.
- A winning state stays as it is while contention persists.
- Any state returns to IDLE when contention ends or slave mode is selected.

Top module: `dp_contention_arb`

## Requirements
- R1: Contention means `lt_sel`=1, `rt_sel`=1 and `lt_addr`==`rt_addr`. If contention starts in master mode, exactly one busy output is low after the next rising edge. With different addresses, or with a port deselected, both busy outputs are high after the next edge.
- R2: Suppose contention starts from IDLE and the right port was not selected at the same address in the previous cycle. Then the left port wins, and `rt_busy_n` goes low at the next edge.
- R3: Suppose contention starts from IDLE, the right port was selected at that address in the previous cycle, and the left port was not. Then the right port keeps priority, and `lt_busy_n` goes low at the next edge.
- R4: The loser's busy stays low on every edge while contention persists. It returns high at the first edge after the winner deselects or moves to another address.
- R5: The values of `lt_wr` and `rt_wr` have no influence on which busy output is driven, or when.
- R6: In master mode, a port's write enable is 0 in two cases: while its busy output is low, and in the cycle in which contention is decided against it.
- R7: Otherwise a port's write enable equals `sel & wr` for that port.
- R8: In slave mode, both busy outputs are high after the next edge. With a busy input held high, that port's write enable equals `sel & wr`.
- R9: In slave mode, a port whose busy input is low has write enable 0.
- R10: While `rst_n` is low, both busy outputs are high.
- R11: The two busy outputs are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode | input | 1 | 1: slave (busy inputs inhibit writes), 0: master (arbitrate) |
| lt_sel | input | 1 | Left port select, active high |
| lt_addr | input | ADDR_W | Left port address |
| lt_wr | input | 1 | Left port write request, 1 = write |
| lt_busy_in_n | input | 1 | Left write-inhibit input in slave mode, active low |
| rt_sel | input | 1 | Right port select, active high |
| rt_addr | input | ADDR_W | Right port address |
| rt_wr | input | 1 | Right port write request, 1 = write |
| rt_busy_in_n | input | 1 | Right write-inhibit input in slave mode, active low |
| lt_busy_n | output | 1 | Busy toward left port, active low |
| rt_busy_n | output | 1 | Busy toward right port, active low |
| lt_wen | output | 1 | Gated write enable to the array for the left port |
| rt_wen | output | 1 | Gated write enable to the array for the right port |

## Verification
The assertions assume that the inputs are synchronous to `clk` and stable around each rising edge. They also assume that `slave_mode` changes only between cycles, so the state register always sees a single mode for a whole cycle. The bench drives every input at the falling edge, so each value is held for a full cycle. Its random phase draws addresses from a four-entry window, which makes collisions, incumbents and winner moves frequent. It also changes mode only at those falling edges.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [1:0] {
        ARB_IDLE       = 2'b00,
        ARB_LEFT_WINS  = 2'b01,
        ARB_RIGHT_WINS = 2'b10
    } arb_state_t;
endpackage

// File: rtl/arb_history.sv
module arb_history #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    output logic              held
);
    logic              sel_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            sel_q  <= sel;
            addr_q <= addr;
        end
    end

    // port was selected at this very address in the previous cycle
    assign held = sel_q && (addr_q == addr);
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
    import arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slave_mode,
    input  logic       contend,
    input  logic       lt_held,
    input  logic       rt_held,
    output arb_state_t state_q,
    output arb_state_t state_d
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (slave_mode || !contend) begin
            state_d = ARB_IDLE;
        end else begin
            unique case (state_q)
                ARB_IDLE: begin
                    if (rt_held && !lt_held) state_d = ARB_RIGHT_WINS;
                    else                     state_d = ARB_LEFT_WINS;
                end
                ARB_LEFT_WINS:  state_d = ARB_LEFT_WINS;
                ARB_RIGHT_WINS: state_d = ARB_RIGHT_WINS;
                default:        state_d = ARB_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wr_gate.sv
module wr_gate (
    input  logic slave_mode,
    input  logic sel,
    input  logic wr,
    input  logic busy_in_n,
    input  logic lost,
    output logic wen
);
    logic inhibit;

    always_comb begin
        inhibit = slave_mode ? !busy_in_n : lost;
        wen     = sel && wr && !inhibit;
    end
endmodule

// File: rtl/dp_contention_arb.sv
module dp_contention_arb
    import arb_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic              lt_sel,
    input  logic [ADDR_W-1:0] lt_addr,
    input  logic              lt_wr,
    input  logic              lt_busy_in_n,
    input  logic              rt_sel,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic              rt_wr,
    input  logic              rt_busy_in_n,
    output logic              lt_busy_n,
    output logic              rt_busy_n,
    output logic              lt_wen,
    output logic              rt_wen
);
    logic       contend, lt_held, rt_held, lt_lost, rt_lost;
    arb_state_t state_q, state_d;

    assign contend = lt_sel && rt_sel && (lt_addr == rt_addr);

    arb_history #(.ADDR_W(ADDR_W)) u_lt_hist (
        .clk(clk), .rst_n(rst_n), .sel(lt_sel), .addr(lt_addr), .held(lt_held));
    arb_history #(.ADDR_W(ADDR_W)) u_rt_hist (
        .clk(clk), .rst_n(rst_n), .sel(rt_sel), .addr(rt_addr), .held(rt_held));

    arb_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .contend(contend),
        .lt_held(lt_held), .rt_held(rt_held), .state_q(state_q), .state_d(state_d));

    always_comb begin
        lt_busy_n = (state_q != ARB_RIGHT_WINS);
        rt_busy_n = (state_q != ARB_LEFT_WINS);
        lt_lost   = (state_d == ARB_RIGHT_WINS) || (state_q == ARB_RIGHT_WINS);
        rt_lost   = (state_d == ARB_LEFT_WINS)  || (state_q == ARB_LEFT_WINS);
    end

    wr_gate u_lt_gate (
        .slave_mode(slave_mode), .sel(lt_sel), .wr(lt_wr),
        .busy_in_n(lt_busy_in_n), .lost(lt_lost), .wen(lt_wen));
    wr_gate u_rt_gate (
        .slave_mode(slave_mode), .sel(rt_sel), .wr(rt_wr),
        .busy_in_n(rt_busy_in_n), .lost(rt_lost), .wen(rt_wen));

    // R11
    one_loser_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!lt_busy_n && !rt_busy_n));
    // R1
    free_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !contend |=> (lt_busy_n && rt_busy_n));
    // R2
    fresh_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && contend && lt_busy_n && rt_busy_n && !rt_held) |=> !rt_busy_n);
    // R4
    hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && contend && !rt_busy_n) |=> !rt_busy_n);
    // R6
    lt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && !lt_busy_n) |-> !lt_wen);
    // R6
    rt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && !rt_busy_n) |-> !rt_wen);
    // R8
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slave_mode |=> (lt_busy_n && rt_busy_n));
    // R9
    slave_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_mode && (!lt_busy_in_n || !rt_busy_in_n)) |->
        ((lt_busy_in_n || !lt_wen) && (rt_busy_in_n || !rt_wen)));
endmodule

// File: tb/dp_contention_arb_test.sv
`timescale 1ns/1ps
module dp_contention_arb_test;
    localparam int AW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slave_mode = 1'b0;
    logic lt_sel = 1'b0, rt_sel = 1'b0, lt_wr = 1'b0, rt_wr = 1'b0;
    logic [AW-1:0] lt_addr = '0, rt_addr = '0;
    logic lt_busy_in_n = 1'b1, rt_busy_in_n = 1'b1;
    logic lt_busy_n, rt_busy_n, lt_wen, rt_wen;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state: 0 none, 1 left owns, 2 right owns
    int owner = 0;
    bit pl_sel = 0, pr_sel = 0;
    int pl_addr = 0, pr_addr = 0;

    always #2.5 clk = ~clk;

    dp_contention_arb #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
        .lt_sel(lt_sel), .lt_addr(lt_addr), .lt_wr(lt_wr), .lt_busy_in_n(lt_busy_in_n),
        .rt_sel(rt_sel), .rt_addr(rt_addr), .rt_wr(rt_wr), .rt_busy_in_n(rt_busy_in_n),
        .lt_busy_n(lt_busy_n), .rt_busy_n(rt_busy_n), .lt_wen(lt_wen), .rt_wen(rt_wen));

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one cycle: drive at negedge, check write enables, clock, check busy
    task automatic step(input string tag, input bit sm,
                        input bit ls, input int la, input bit lw, input bit lb,
                        input bit rs, input int ra, input bit rw, input bit rb);
        bit contend, lheld, rheld, elw, erw;
        int nxt;
        slave_mode = sm; lt_sel = ls; lt_addr = la[AW-1:0]; lt_wr = lw; lt_busy_in_n = lb;
        rt_sel = rs; rt_addr = ra[AW-1:0]; rt_wr = rw; rt_busy_in_n = rb;
        #1;
        contend = ls && rs && (la == ra);
        lheld = pl_sel && (pl_addr == la);
        rheld = pr_sel && (pr_addr == ra);
        if (sm || !contend) nxt = 0;
        else if (owner != 0) nxt = owner;
        else if (rheld && !lheld) nxt = 2;
        else nxt = 1;
        if (sm) begin
            elw = ls && lw && lb;
            erw = rs && rw && rb;
        end else begin
            elw = ls && lw && !(nxt == 2 || owner == 2);
            erw = rs && rw && !(nxt == 1 || owner == 1);
        end
        chk(tag, "lt_wen", lt_wen, elw);
        chk(tag, "rt_wen", rt_wen, erw);
        @(posedge clk);
        owner = nxt;
        pl_sel = ls; pl_addr = la; pr_sel = rs; pr_addr = ra;
        @(negedge clk);
        chk(tag, "lt_busy_n", lt_busy_n, owner != 2);
        chk(tag, "rt_busy_n", rt_busy_n, owner != 1);
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "lt_busy_n", lt_busy_n, 1'b1);
        chk("R10", "rt_busy_n", rt_busy_n, 1'b1);
        rst_n = 1'b1;

        // R1: different addresses, no busy
        step("R1", 0, 1, 5, 1, 1, 1, 6, 1, 1);
        step("R1", 0, 1, 5, 0, 1, 0, 5, 1, 1);
        step("R1", 0, 0, 0, 0, 1, 0, 0, 0, 1);
        // R2: fresh contention, left wins; R6/R7 writes
        step("R2", 0, 1, 9, 1, 1, 1, 9, 1, 1);
        step("R4", 0, 1, 9, 1, 1, 1, 9, 1, 1);
        step("R4", 0, 1, 9, 0, 1, 1, 9, 1, 1);
        // R4: winner deselects, release next edge
        step("R4", 0, 0, 9, 0, 1, 1, 9, 1, 1);
        step("R7", 0, 0, 9, 0, 1, 1, 9, 1, 1);
        // R3: right holds 9, left arrives
        step("R3", 0, 1, 9, 1, 1, 1, 9, 1, 1);
        step("R6", 0, 1, 9, 1, 1, 1, 9, 0, 1);
        // R4: winner moves away
        step("R4", 0, 1, 9, 1, 1, 1, 12, 1, 1);
        step("R4", 0, 1, 9, 1, 1, 1, 12, 1, 1);
        // R5: read/read contention behaves as write/write
        step("R5", 0, 0, 0, 0, 1, 0, 0, 0, 1);
        step("R5", 0, 1, 3, 0, 1, 1, 3, 0, 1);
        step("R5", 0, 1, 3, 0, 1, 1, 3, 0, 1);
        step("R5", 0, 0, 3, 0, 1, 0, 3, 0, 1);
        step("R5", 0, 1, 3, 1, 1, 1, 3, 1, 1);
        // R8: slave mode, no arbitration, normal writes
        step("R8", 1, 1, 3, 1, 1, 1, 3, 1, 1);
        step("R8", 1, 1, 3, 1, 1, 1, 3, 1, 1);
        // R9: slave inhibit inputs
        step("R9", 1, 1, 3, 1, 0, 1, 3, 1, 1);
        step("R9", 1, 1, 4, 1, 1, 1, 8, 1, 0);
        step("R9", 1, 1, 4, 1, 0, 1, 8, 1, 0);
        // R11 and all above: random mixed traffic in a tiny address window
        for (int i = 0; i < 600; i++) begin
            step("R11", ($urandom % 8) == 0,
                 $urandom % 4 != 0, $urandom % 4, $urandom % 2, $urandom % 4 != 0,
                 $urandom % 4 != 0, $urandom % 4, $urandom % 2, $urandom % 4 != 0);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule